// File: doc/BRIEF.md
# Full-Map Coherence Directory Home Controller

This block is the home-node directory for a fixed set of memory blocks shared by several private caches. Each block has one entry. The entry holds an exact presence vector with one bit per cache, an exclusive flag that marks a single owner, and the bookkeeping for one transaction in flight. Caches send read, read-for-ownership and upgrade requests to the directory. The directory either answers at once, or it probes the current holders and answers once every probed cache has acknowledged.

Invalidations are explicit, one probe message carrying a destination mask. A read that finds a foreign exclusive owner sends that owner a downgrade probe. While an entry waits for acknowledgements it is busy, and any request that reaches it is refused with a negative reply so that the requester retries. At most one request is accepted per cycle. Every message leaves through a registered output one cycle after the event that caused it.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is empty: no presence bit, not exclusive, not busy. `req_ready` is high and `resp_valid` and `probe_valid` are low.
- R2: Request opcodes are 0 = read, 1 = read-exclusive, 2 = upgrade. Reply kinds are 0 = shared data, 1 = exclusive data, 2 = upgrade granted (no data), 3 = NACK. A read to an entry that is not exclusive replies kind 0 to the requester in the next cycle and adds the requester's presence bit.
- R3: A read-exclusive sends, in the next cycle, one probe of kind 0 (invalidate) whose mask holds every present cache except the requester, with `probe_src` equal to the requester. If that mask would be empty, it replies kind 1 at once without becoming busy.
- R4: After a read-exclusive or upgrade is granted, the entry holds only the requester's presence bit and is exclusive.
- R5: A read that finds an exclusive owner other than the requester sends a probe of kind 1 (downgrade) to that owner alone. After the owner's acknowledgement it replies kind 0, both caches are present and the entry is no longer exclusive. A read by the owner itself gets an immediate kind 1 reply and leaves the entry unchanged.
- R6: An upgrade from a cache whose presence bit is set behaves like a read-exclusive but replies kind 2. An upgrade from a cache that is not present gets a kind 3 reply and leaves the entry unchanged.
- R7: Any request to a busy entry gets a kind 3 reply in the next cycle and leaves the entry unchanged.
- R8: A busy entry counts the acknowledgements it still needs, starting from the number of probe targets. The reply is sent in the cycle after the last one. An acknowledgement counts only if it names the busy block and comes from a probed cache. All other acknowledgements are ignored.
- R9: `req_ready` is low in every cycle in which `ack_valid` is high.
- R10: Every accepted request produces exactly one reply or one probe in the next cycle. A reply and a probe never appear in the same cycle.
- R11: A busy entry does not change how requests to other blocks are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_node | input | $clog2(NODES) | Requesting cache |
| req_blk | input | $clog2(BLOCKS) | Target block |
| req_op | input | 2 | Request opcode |
| resp_valid | output | 1 | Reply present |
| resp_node | output | $clog2(NODES) | Cache that receives the reply |
| resp_blk | output | $clog2(BLOCKS) | Block of the reply |
| resp_kind | output | 2 | Reply kind |
| probe_valid | output | 1 | Probe present |
| probe_kind | output | 1 | 0 invalidate, 1 downgrade |
| probe_mask | output | NODES | Caches addressed by the probe |
| probe_src | output | $clog2(NODES) | Cache whose request caused the probe |
| probe_blk | output | $clog2(BLOCKS) | Probed block |
| ack_valid | input | 1 | Probe acknowledgement present |
| ack_node | input | $clog2(NODES) | Acknowledging cache |
| ack_blk | input | $clog2(BLOCKS) | Acknowledged block |

## Verification
The hardest situation to reach is a request that lands on an entry in the middle of its acknowledgement window. This needs a prior sharer set built up through the ports, then a read-exclusive that leaves several acknowledgements outstanding. The stimulus builds every presence pattern of a four-cache configuration from reset, using an exclusive fetch followed by reads. It then fires each opcode from each cache and reveals the resulting entry with a further read-exclusive. A dedicated sequence interleaves refused requests, a stray acknowledgement from the requester, and traffic to an unrelated block between the individual acknowledgements.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_READEX  = 2'd1,
        OP_UPGRADE = 2'd2,
        OP_RSVD    = 2'd3
    } dir_op_e;

    typedef enum logic [1:0] {
        RSP_SHARED = 2'd0,
        RSP_EXCL   = 2'd1,
        RSP_UPG    = 2'd2,
        RSP_NACK   = 2'd3
    } dir_rsp_e;

    typedef enum logic {
        PRB_INV  = 1'b0,
        PRB_DOWN = 1'b1
    } dir_prb_e;

    // Reply sent when a probed transaction finishes
    function automatic dir_rsp_e finish_kind(input dir_op_e op);
        case (op)
            OP_READ:    return RSP_SHARED;
            OP_UPGRADE: return RSP_UPG;
            default:    return RSP_EXCL;
        endcase
    endfunction

endpackage

// File: rtl/dir_entry_table.sv
module dir_entry_table
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int CW     = 3,
    parameter int NW     = 2,
    parameter int BW     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BW-1:0]    wr_blk,
    input  logic [NODES-1:0] wr_pres,
    input  logic             wr_excl,
    input  logic             wr_busy,
    input  logic [CW-1:0]    wr_cnt,
    input  logic [NW-1:0]    wr_pnode,
    input  dir_op_e          wr_pop,
    input  logic [BW-1:0]    rd_blk,
    output logic [NODES-1:0] rd_pres,
    output logic             rd_excl,
    output logic             rd_busy,
    output logic [CW-1:0]    rd_cnt,
    output logic [NW-1:0]    rd_pnode,
    output dir_op_e          rd_pop
);

    logic [NODES-1:0] pres_q  [BLOCKS];
    logic             excl_q  [BLOCKS];
    logic             busy_q  [BLOCKS];
    logic [CW-1:0]    cnt_q   [BLOCKS];
    logic [NW-1:0]    pnode_q [BLOCKS];
    dir_op_e          pop_q   [BLOCKS];

    for (genvar g = 0; g < BLOCKS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                pres_q[g]  <= '0;
                excl_q[g]  <= 1'b0;
                busy_q[g]  <= 1'b0;
                cnt_q[g]   <= '0;
                pnode_q[g] <= '0;
                pop_q[g]   <= OP_READ;
            end else if (wr_en && (wr_blk == BW'(g))) begin
                pres_q[g]  <= wr_pres;
                excl_q[g]  <= wr_excl;
                busy_q[g]  <= wr_busy;
                cnt_q[g]   <= wr_cnt;
                pnode_q[g] <= wr_pnode;
                pop_q[g]   <= wr_pop;
            end
        end
    end

    assign rd_pres  = pres_q[rd_blk];
    assign rd_excl  = excl_q[rd_blk];
    assign rd_busy  = busy_q[rd_blk];
    assign rd_cnt   = cnt_q[rd_blk];
    assign rd_pnode = pnode_q[rd_blk];
    assign rd_pop   = pop_q[rd_blk];

endmodule

// File: rtl/dir_req_decide.sv
module dir_req_decide
    import dir_pkg::*;
#(
    parameter int NODES = 4,
    parameter int CW    = 3,
    parameter int NW    = 2
) (
    input  logic [NODES-1:0] cur_pres,
    input  logic             cur_excl,
    input  logic             cur_busy,
    input  logic [NW-1:0]    req_node,
    input  dir_op_e          req_op,
    output logic [NODES-1:0] nxt_pres,
    output logic             nxt_excl,
    output logic             nxt_busy,
    output logic [CW-1:0]    nxt_cnt,
    output logic             rsp_fire,
    output dir_rsp_e         rsp_kind,
    output logic             prb_fire,
    output dir_prb_e         prb_kind,
    output logic [NODES-1:0] prb_mask
);

    logic [NODES-1:0] self_bit;
    logic [NODES-1:0] others;
    logic [CW-1:0]    tgt_cnt;

    always_comb begin
        self_bit = '0;
        self_bit[req_node] = 1'b1;
        others = cur_pres & ~self_bit;
        tgt_cnt = '0;
        for (int i = 0; i < NODES; i++) begin
            tgt_cnt = tgt_cnt + CW'(others[i]);
        end
    end

    always_comb begin
        nxt_pres = cur_pres;
        nxt_excl = cur_excl;
        nxt_busy = cur_busy;
        nxt_cnt  = '0;
        rsp_fire = 1'b0;
        rsp_kind = RSP_NACK;
        prb_fire = 1'b0;
        prb_kind = PRB_INV;
        prb_mask = others;
        if (cur_busy) begin
            rsp_fire = 1'b1;
            rsp_kind = RSP_NACK;
        end else begin
            case (req_op)
                OP_READ: begin
                    if (cur_excl && (others != '0)) begin
                        prb_fire = 1'b1;
                        prb_kind = PRB_DOWN;
                        nxt_busy = 1'b1;
                        nxt_cnt  = tgt_cnt;
                    end else if (cur_excl) begin
                        rsp_fire = 1'b1;
                        rsp_kind = RSP_EXCL;
                    end else begin
                        rsp_fire = 1'b1;
                        rsp_kind = RSP_SHARED;
                        nxt_pres = cur_pres | self_bit;
                    end
                end
                OP_READEX, OP_UPGRADE: begin
                    if ((req_op == OP_UPGRADE) && !cur_pres[req_node]) begin
                        rsp_fire = 1'b1;
                        rsp_kind = RSP_NACK;
                    end else if (others == '0) begin
                        rsp_fire = 1'b1;
                        rsp_kind = finish_kind(req_op);
                        nxt_pres = self_bit;
                        nxt_excl = 1'b1;
                    end else begin
                        prb_fire = 1'b1;
                        prb_kind = PRB_INV;
                        nxt_busy = 1'b1;
                        nxt_cnt  = tgt_cnt;
                    end
                end
                default: begin
                    rsp_fire = 1'b1;
                    rsp_kind = RSP_NACK;
                end
            endcase
        end
    end

endmodule

// File: rtl/dir_ack_track.sv
module dir_ack_track
    import dir_pkg::*;
#(
    parameter int NODES = 4,
    parameter int CW    = 3,
    parameter int NW    = 2
) (
    input  logic             ack_valid,
    input  logic [NW-1:0]    ack_node,
    input  logic [NODES-1:0] cur_pres,
    input  logic             cur_excl,
    input  logic             cur_busy,
    input  logic [CW-1:0]    cur_cnt,
    input  logic [NW-1:0]    cur_pnode,
    input  dir_op_e          cur_pop,
    output logic             wr_en,
    output logic [NODES-1:0] nxt_pres,
    output logic             nxt_excl,
    output logic             nxt_busy,
    output logic [CW-1:0]    nxt_cnt,
    output logic             done,
    output dir_rsp_e         done_kind
);

    logic [NODES-1:0] owner_bit;
    logic             counts;

    always_comb begin
        owner_bit = '0;
        owner_bit[cur_pnode] = 1'b1;
        counts = ack_valid && cur_busy && cur_pres[ack_node] && (ack_node != cur_pnode);
    end

    always_comb begin
        wr_en     = counts;
        nxt_pres  = cur_pres;
        nxt_excl  = cur_excl;
        nxt_busy  = cur_busy;
        nxt_cnt   = cur_cnt;
        done      = 1'b0;
        done_kind = finish_kind(cur_pop);
        if (counts) begin
            if (cur_cnt <= CW'(1)) begin
                done     = 1'b1;
                nxt_busy = 1'b0;
                nxt_cnt  = '0;
                if (cur_pop == OP_READ) begin
                    nxt_pres = cur_pres | owner_bit;
                    nxt_excl = 1'b0;
                end else begin
                    nxt_pres = owner_bit;
                    nxt_excl = 1'b1;
                end
            end else begin
                nxt_cnt = cur_cnt - CW'(1);
            end
        end
    end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter  int NODES  = 4,
    parameter  int BLOCKS = 16,
    localparam int NW     = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int BW     = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [NW-1:0]    req_node,
    input  logic [BW-1:0]    req_blk,
    input  logic [1:0]       req_op,
    output logic             resp_valid,
    output logic [NW-1:0]    resp_node,
    output logic [BW-1:0]    resp_blk,
    output logic [1:0]       resp_kind,
    output logic             probe_valid,
    output logic             probe_kind,
    output logic [NODES-1:0] probe_mask,
    output logic [NW-1:0]    probe_src,
    output logic [BW-1:0]    probe_blk,
    input  logic             ack_valid,
    input  logic [NW-1:0]    ack_node,
    input  logic [BW-1:0]    ack_blk
);

    localparam int CW = $clog2(NODES + 1);

    dir_op_e          op_in;
    logic             accept;
    logic [BW-1:0]    rd_blk;

    logic [NODES-1:0] cur_pres;
    logic             cur_excl, cur_busy;
    logic [CW-1:0]    cur_cnt;
    logic [NW-1:0]    cur_pnode;
    dir_op_e          cur_pop;

    logic [NODES-1:0] d_pres, a_pres, w_pres;
    logic             d_excl, a_excl, w_excl;
    logic             d_busy, a_busy, w_busy;
    logic [CW-1:0]    d_cnt, a_cnt, w_cnt;
    logic             d_rsp_fire, d_prb_fire, a_wr, a_done, w_en;
    dir_rsp_e         d_rsp_kind, a_done_kind;
    dir_prb_e         d_prb_kind;
    logic [NODES-1:0] d_prb_mask;
    logic [NW-1:0]    w_pnode;
    dir_op_e          w_pop;

    dir_rsp_e         resp_kind_q;
    dir_prb_e         probe_kind_q;

    assign op_in     = dir_op_e'(req_op);
    assign req_ready = !ack_valid;
    assign accept    = req_valid && req_ready;
    assign rd_blk    = ack_valid ? ack_blk : req_blk;

    dir_entry_table #(
        .NODES(NODES), .BLOCKS(BLOCKS), .CW(CW), .NW(NW), .BW(BW)
    ) table_i (
        .clk(clk), .rst(rst),
        .wr_en(w_en), .wr_blk(rd_blk), .wr_pres(w_pres), .wr_excl(w_excl),
        .wr_busy(w_busy), .wr_cnt(w_cnt), .wr_pnode(w_pnode), .wr_pop(w_pop),
        .rd_blk(rd_blk), .rd_pres(cur_pres), .rd_excl(cur_excl), .rd_busy(cur_busy),
        .rd_cnt(cur_cnt), .rd_pnode(cur_pnode), .rd_pop(cur_pop)
    );

    dir_req_decide #(.NODES(NODES), .CW(CW), .NW(NW)) decide_i (
        .cur_pres(cur_pres), .cur_excl(cur_excl), .cur_busy(cur_busy),
        .req_node(req_node), .req_op(op_in),
        .nxt_pres(d_pres), .nxt_excl(d_excl), .nxt_busy(d_busy), .nxt_cnt(d_cnt),
        .rsp_fire(d_rsp_fire), .rsp_kind(d_rsp_kind),
        .prb_fire(d_prb_fire), .prb_kind(d_prb_kind), .prb_mask(d_prb_mask)
    );

    dir_ack_track #(.NODES(NODES), .CW(CW), .NW(NW)) ack_i (
        .ack_valid(ack_valid), .ack_node(ack_node),
        .cur_pres(cur_pres), .cur_excl(cur_excl), .cur_busy(cur_busy),
        .cur_cnt(cur_cnt), .cur_pnode(cur_pnode), .cur_pop(cur_pop),
        .wr_en(a_wr), .nxt_pres(a_pres), .nxt_excl(a_excl), .nxt_busy(a_busy),
        .nxt_cnt(a_cnt), .done(a_done), .done_kind(a_done_kind)
    );

    // One write port: acknowledgements and requests never share a cycle
    always_comb begin
        if (ack_valid) begin
            w_en    = a_wr;
            w_pres  = a_pres;
            w_excl  = a_excl;
            w_busy  = a_busy;
            w_cnt   = a_cnt;
            w_pnode = cur_pnode;
            w_pop   = cur_pop;
        end else begin
            // A refused request must leave the pending fields intact
            w_en    = accept && !cur_busy;
            w_pres  = d_pres;
            w_excl  = d_excl;
            w_busy  = d_busy;
            w_cnt   = d_cnt;
            w_pnode = req_node;
            w_pop   = op_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid   <= 1'b0;
            resp_node    <= '0;
            resp_blk     <= '0;
            resp_kind_q  <= RSP_SHARED;
            probe_valid  <= 1'b0;
            probe_kind_q <= PRB_INV;
            probe_mask   <= '0;
            probe_src    <= '0;
            probe_blk    <= '0;
        end else begin
            resp_valid  <= (accept && d_rsp_fire) || (ack_valid && a_done);
            probe_valid <= accept && d_prb_fire;
            if (accept) begin
                resp_node    <= req_node;
                resp_blk     <= req_blk;
                resp_kind_q  <= d_rsp_kind;
                probe_kind_q <= d_prb_kind;
                probe_mask   <= d_prb_mask;
                probe_src    <= req_node;
                probe_blk    <= req_blk;
            end else if (ack_valid && a_done) begin
                resp_node   <= cur_pnode;
                resp_blk    <= ack_blk;
                resp_kind_q <= a_done_kind;
            end
        end
    end

    assign resp_kind  = resp_kind_q;
    assign probe_kind = probe_kind_q;

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
    parameter  int NODES  = 4,
    parameter  int BLOCKS = 16,
    localparam int NW     = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int BW     = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [BW-1:0]    req_blk,
    input logic             resp_valid,
    input logic [BW-1:0]    resp_blk,
    input logic [1:0]       resp_kind,
    input logic             probe_valid,
    input logic             probe_kind,
    input logic [NODES-1:0] probe_mask,
    input logic [NW-1:0]    probe_src,
    input logic [BW-1:0]    probe_blk
);

    logic [BLOCKS-1:0] seen_busy;
    logic              grant_out;
    logic              busy_hit;

    assign grant_out = resp_valid && (resp_kind != 2'd3);
    assign busy_hit  = (seen_busy[req_blk] || (probe_valid && (probe_blk == req_blk)))
                       && !(grant_out && (resp_blk == req_blk));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_busy <= '0;
        end else begin
            if (probe_valid) seen_busy[probe_blk] <= 1'b1;
            if (grant_out)   seen_busy[resp_blk]  <= 1'b0;
        end
    end

    AST_PROBE_SKIPS_SRC: assert property (@(posedge clk) disable iff (rst)
        probe_valid |-> (probe_mask[probe_src] == 1'b0 && probe_mask != '0)); // R3

    AST_DOWN_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        (probe_valid && probe_kind) |-> $onehot(probe_mask)); // R5

    AST_BUSY_GETS_NACK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && busy_hit) |=> (resp_valid && resp_kind == 2'd3)); // R7

    AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (resp_valid || probe_valid)); // R10

    AST_NO_DOUBLE_OUT: assert property (@(posedge clk) disable iff (rst)
        !(resp_valid && probe_valid)); // R10

endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .BLOCKS(BLOCKS)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_blk(req_blk), .resp_valid(resp_valid), .resp_blk(resp_blk),
    .resp_kind(resp_kind), .probe_valid(probe_valid), .probe_kind(probe_kind),
    .probe_mask(probe_mask), .probe_src(probe_src), .probe_blk(probe_blk)
);

// File: tb/dir_home_ctrl_tb_top.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb_top;

    localparam int NODES  = 4;
    localparam int BLOCKS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_ready;
    logic [1:0] req_node = '0;
    logic [3:0] req_blk = '0;
    logic [1:0] req_op = '0;
    logic       resp_valid;
    logic [1:0] resp_node;
    logic [3:0] resp_blk;
    logic [1:0] resp_kind;
    logic       probe_valid, probe_kind;
    logic [3:0] probe_mask;
    logic [1:0] probe_src;
    logic [3:0] probe_blk;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_node = '0;
    logic [3:0] ack_blk = '0;

    always #2 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS)) dut_i (.*);

    int checks = 0;
    int fails  = 0;
    logic [3:0] m_pres [BLOCKS];
    logic       m_excl [BLOCKS];

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < BLOCKS; b++) begin
            m_pres[b] = '0;
            m_excl[b] = 1'b0;
        end
    endtask

    task automatic issue(input int n, input int b, input int op);
        req_node = 2'(n); req_blk = 4'(b); req_op = 2'(op); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack(input int n, input int b);
        ack_node = 2'(n); ack_blk = 4'(b); ack_valid = 1'b1;
        #1 chk("R9", "req_ready during ack", int'(req_ready), 0);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic expect_resp(input string rq, input int n, input int b, input int kind);
        chk(rq, "resp_valid", int'(resp_valid), 1);
        chk(rq, "resp_kind", int'(resp_kind), kind);
        chk(rq, "resp_node", int'(resp_node), n);
        chk(rq, "resp_blk", int'(resp_blk), b);
        chk("R10", "probe_valid with reply", int'(probe_valid), 0);
    endtask

    // Issue one request, answer every probe, check against the model
    task automatic do_req(input int n, input int b, input int op);
        logic [3:0] self_b, others, pmask, fin_pres;
        logic       fin_excl;
        bit         probe;
        int         kind, pkind, left;
        string      rq;
        self_b = 4'(1 << n);
        others = m_pres[b] & ~self_b;
        probe = 0; pmask = others; pkind = 0;
        fin_pres = m_pres[b]; fin_excl = m_excl[b];
        if (op == 0) begin
            if (m_excl[b] && others != 0) begin
                probe = 1; pkind = 1; kind = 0; rq = "R5";
                fin_pres = m_pres[b] | self_b; fin_excl = 0;
            end else if (m_excl[b]) begin
                kind = 1; rq = "R5";
            end else begin
                kind = 0; rq = "R2"; fin_pres = m_pres[b] | self_b;
            end
        end else if (op == 2 && !m_pres[b][n]) begin
            kind = 3; rq = "R6";
        end else begin
            kind = (op == 2) ? 2 : 1;
            rq = (op == 2) ? "R6" : "R3";
            probe = (others != 0);
            fin_pres = self_b; fin_excl = 1;
        end
        issue(n, b, op);
        if (probe) begin
            chk(rq, "probe_valid", int'(probe_valid), 1);
            chk(rq, "probe_mask", int'(probe_mask), int'(pmask));
            chk(rq, "probe_kind", int'(probe_kind), pkind);
            chk("R3", "probe_src", int'(probe_src), n);
            chk(rq, "probe_blk", int'(probe_blk), b);
            chk("R10", "resp with probe", int'(resp_valid), 0);
            left = $countones(pmask);
            for (int i = 0; i < NODES; i++) begin
                if (pmask[i]) begin
                    left--;
                    ack(i, b);
                    if (left == 0) expect_resp("R4", n, b, kind);
                    else chk("R8", "early reply", int'(resp_valid), 0);
                end
            end
        end else begin
            expect_resp(rq, n, b, kind);
        end
        m_pres[b] = fin_pres;
        m_excl[b] = fin_excl;
    endtask

    task automatic build(input int mask, input int b);
        bit first = 1;
        for (int i = 0; i < NODES; i++) begin
            if (mask[i]) begin
                do_req(i, b, first ? 1 : 0);
                first = 0;
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1", "resp_valid after reset", int'(resp_valid), 0);
        chk("R1", "probe_valid after reset", int'(probe_valid), 0);
        chk("R1", "req_ready after reset", int'(req_ready), 1);

        // Every presence pattern x requester x opcode, then reveal the state
        for (int mask = 0; mask < 16; mask++) begin
            for (int n = 0; n < NODES; n++) begin
                for (int op = 0; op < 3; op++) begin
                    do_reset();
                    build(mask, mask);
                    do_req(n, mask, op);
                    do_req((n + 1) % NODES, mask, 1);
                end
            end
        end

        // Busy window: NACKs, stray ack, other block unaffected
        do_reset();
        build(4'b0111, 3);
        issue(3, 3, 1);
        chk("R3", "probe mask busy case", int'(probe_mask), 7);
        issue(1, 3, 0);
        expect_resp("R7", 1, 3, 3);
        ack(0, 3);
        chk("R8", "reply after first ack", int'(resp_valid), 0);
        ack(3, 3);
        chk("R8", "stray ack from requester", int'(resp_valid), 0);
        issue(2, 3, 2);
        expect_resp("R7", 2, 3, 3);
        do_req(0, 4, 0);
        chk("R11", "other block probe", int'(probe_valid), 0);
        ack(1, 3);
        chk("R8", "reply after second ack", int'(resp_valid), 0);
        ack(2, 3);
        expect_resp("R4", 3, 3, 1);
        m_pres[3] = 4'b1000; m_excl[3] = 1'b1;
        do_req(0, 3, 1);

        // Acks to an idle entry are ignored
        do_reset();
        do_req(2, 5, 1);
        ack(1, 5);
        chk("R8", "ack to idle entry", int'(resp_valid), 0);
        ack(2, 5);
        chk("R8", "ack from owner idle", int'(resp_valid), 0);
        do_req(0, 5, 0);
        do_req(1, 5, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule